// File: doc/BRIEF.md
# Smart Card UART Interrupt Controller

This block gathers the status flags of a half-duplex smart card UART and folds them into one active-low interrupt line. Six error and timeout flags are set by single-cycle pulses from the framing engine. They stay set until software reads the status register. The read strobe is active low and asynchronous. On its falling edge the block takes a snapshot of all flags, and that snapshot is what the status register returns. Only the flags held in the snapshot are cleared, a fixed delay after the strobe's rising edge. A flag that arrives during the read is therefore kept for the next read.

A seventh flag is shared between two uses: transmit buffer empty in transmit mode and receive buffer full in receive mode. Software can mask it from the interrupt line. A status read does not clear it. It clears two cycles after a write to the transmit register or a read of the receive register. It also clears when the UART leaves transmit mode, provided the FIFO was not full when transmit mode was entered. While a last-character marker is active in transmit mode, the end of that transmission does not set the flag.

Top module: `sc_irq_ctrl`

## Requirements
- R1: If any error flag is set after a clock edge, irq_n is low after the next edge. The error flags are bit 0 framing, bit 1 overrun, bit 2 parity, bit 3 early answer, bit 4 timeout A and bit 5 timeout B.
- R2: stat_rd_n passes through a two-flop synchroniser. Its falling edge loads stat_rdata with the flags: bits 5..0 hold the error flags and bit 6 holds the shared buffer flag.
- R3: Let edge m be the first clock edge that samples stat_rd_n high. The flags present in the snapshot clear on edge m+4. Flags that were not in the snapshot stay set.
- R4: If an error set pulse arrives in the same cycle as that flag's clear, the flag stays set.
- R5: When buf_irq_mask is 0, the buffer flag drives irq_n low. When the mask is 1, the flag has no effect on irq_n but still appears in bit 6 of the snapshot.
- R6: If tx_wr is sampled high at edge w, the buffer flag clears at edge w+2.
- R7: If rx_rd is sampled high at edge r, the buffer flag clears at edge r+2.
- R8: When tx_mode falls, the buffer flag clears on that edge, but only if fifo_full was low on the edge that sampled tx_mode rising. Otherwise the flag is kept.
- R9: While tx_mode and last_char are both high, a buf_set pulse does not set the buffer flag.
- R10: After reset, all flags and the snapshot are zero and irq_n is high.
- R11: irq_n is registered. It rises on the edge after the one that clears the last pending unmasked flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_set | input | 6 | Set pulses for the six error/timeout flags |
| buf_set | input | 1 | Set pulse for the shared buffer flag |
| last_char | input | 1 | Marks the character being sent as the final one |
| tx_mode | input | 1 | 1 = transmit mode, 0 = receive mode |
| fifo_full | input | 1 | FIFO full indication |
| buf_irq_mask | input | 1 | 1 masks the buffer flag from irq_n |
| stat_rd_n | input | 1 | Asynchronous active-low status read strobe |
| tx_wr | input | 1 | Transmit register write strobe |
| rx_rd | input | 1 | Receive register read strobe |
| stat_rdata | output | 7 | Status snapshot |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench measures the exact edge on which a status read clears a flag and the edge on which irq_n releases. A design with a short or long delay, or with the interrupt output unregistered, would release the line one edge off. It raises a flag after the snapshot has been taken, and it raises a flag on the very edge of its clear. A design that cleared the live flags, or gave the clear priority, would lose that event. It enters transmit mode twice, once with the FIFO empty and once with it full, so a design that ignored the entry condition would drop the buffer flag wrongly. It also sends a marked last character and toggles the mask, to catch a flag that is set when it should be suppressed or an interrupt that ignores the mask.

// File: rtl/sc_irq_pkg.sv
// Shared defaults and flag bit positions for the smart card interrupt controller.
// Assumes consumers import it before declaring parameters.
package sc_irq_pkg;
    localparam int SC_NUM_ERR     = 6;
    localparam int SC_SYNC_STAGES = 2;
    localparam int SC_CLR_DELAY   = 2;
    localparam int SC_BIT_FRAME   = 0;
    localparam int SC_BIT_OVERRUN = 1;
    localparam int SC_BIT_PARITY  = 2;
    localparam int SC_BIT_EARLY   = 3;
    localparam int SC_BIT_TMO_A   = 4;
    localparam int SC_BIT_TMO_B   = 5;
    localparam int SC_BIT_BUF     = SC_NUM_ERR;
endpackage

// File: rtl/sc_strobe_sync.sv
// Brings an asynchronous active-low strobe into the clock domain and reports
// its falling and rising edges as one-cycle pulses. Assumes STAGES >= 2 and
// that the strobe idles high.
module sc_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strb_n,
    output logic fall_p,
    output logic rise_p
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the strobe through the synchroniser and keep the previous stable value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], strb_n};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign fall_p = last_q & ~sync_q[STAGES-1];
    assign rise_p = ~last_q & sync_q[STAGES-1];
endmodule

// File: rtl/sc_clr_delay.sv
// Emits a one-cycle clear request DELAY cycles after a start pulse. A new start
// reloads the count. Assumes DELAY >= 1.
module sc_clr_delay #(
    parameter int DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic clr_p
);
    localparam int CNT_W = $clog2(DELAY + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(DELAY);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign clr_p = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sc_buf_flag.sv
// Holds the shared transmit-empty / receive-full flag. It handles the last-character
// suppression and the clear on leaving transmit mode. Assumes the clear pulses
// are already delayed.
module sc_buf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_p,
    input  logic last_char,
    input  logic tx_mode,
    input  logic fifo_full,
    input  logic clr_p,
    output logic flag_q,
    output logic exit_clr
);
    logic tx_q;
    logic full_at_entry_q;
    logic enter;
    logic set_eff;

    assign enter    = tx_mode & ~tx_q;
    assign exit_clr = ~tx_mode & tx_q & ~full_at_entry_q;
    assign set_eff  = set_p & ~(tx_mode & last_char);

    // Track the mode and remember the FIFO state when transmit mode is entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q            <= 1'b0;
            full_at_entry_q <= 1'b0;
        end else begin
            tx_q <= tx_mode;
            if (enter) begin
                full_at_entry_q <= fifo_full;
            end
        end
    end

    // Update the flag; a set in the same cycle as a clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= (flag_q & ~(clr_p | exit_clr)) | set_eff;
        end
    end
endmodule

// File: rtl/sc_irq_ctrl.sv
// Top of the smart card UART interrupt controller. It holds the error flags,
// takes the status snapshot, clears the read flags after a delay and drives
// the registered active-low interrupt. Assumes single-cycle set pulses and
// synchronous tx_wr / rx_rd strobes.
module sc_irq_ctrl
    import sc_irq_pkg::*;
#(
    parameter int NUM_ERR     = SC_NUM_ERR,
    parameter int SYNC_STAGES = SC_SYNC_STAGES,
    parameter int CLR_DELAY   = SC_CLR_DELAY
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ERR-1:0] err_set,
    input  logic               buf_set,
    input  logic               last_char,
    input  logic               tx_mode,
    input  logic               fifo_full,
    input  logic               buf_irq_mask,
    input  logic               stat_rd_n,
    input  logic               tx_wr,
    input  logic               rx_rd,
    output logic [NUM_ERR:0]   stat_rdata,
    output logic               irq_n
);
    localparam int STAT_W  = NUM_ERR + 1;
    localparam int N_BUFCL = 2;

    logic               rd_fall;
    logic               rd_rise;
    logic               stat_clr;
    logic [N_BUFCL-1:0] buf_strb;
    logic [N_BUFCL-1:0] buf_clr_vec;
    logic               buf_q;
    logic               mode_exit_clr;
    logic [NUM_ERR-1:0] err_q;
    logic [STAT_W-1:0]  snap_q;

    sc_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .strb_n (stat_rd_n),
        .fall_p (rd_fall),
        .rise_p (rd_rise)
    );

    sc_clr_delay #(.DELAY(CLR_DELAY)) u_stat_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rd_rise),
        .clr_p (stat_clr)
    );

    assign buf_strb = {rx_rd, tx_wr};

    generate
        for (genvar g = 0; g < N_BUFCL; g++) begin : g_buf_dly
            sc_clr_delay #(.DELAY(CLR_DELAY)) u_dly (
                .clk   (clk),
                .rst_n (rst_n),
                .start (buf_strb[g]),
                .clr_p (buf_clr_vec[g])
            );
        end
    endgenerate

    sc_buf_flag u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_p     (buf_set),
        .last_char (last_char),
        .tx_mode   (tx_mode),
        .fifo_full (fifo_full),
        .clr_p     (|buf_clr_vec),
        .flag_q    (buf_q),
        .exit_clr  (mode_exit_clr)
    );

    generate
        for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
            // Set on a pulse; clear only if the flag was in the last snapshot.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    err_q[i] <= 1'b0;
                end else if (err_set[i]) begin
                    err_q[i] <= 1'b1;
                end else if (stat_clr && snap_q[i]) begin
                    err_q[i] <= 1'b0;
                end
            end
        end
    endgenerate

    // Capture all flags at the start of a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (rd_fall) begin
            snap_q <= {buf_q, err_q};
        end
    end

    // Drive the interrupt from any error or the unmasked buffer flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n <= 1'b1;
        end else begin
            irq_n <= ~((|err_q) | (buf_q & ~buf_irq_mask));
        end
    end

    assign stat_rdata = snap_q;
endmodule

// File: rtl/sc_irq_ctrl_chk.sv
// Checker bound to sc_irq_ctrl. It relates the flag state to the interrupt line
// and to the set and clear rules.
module sc_irq_ctrl_chk #(
    parameter int NUM_ERR = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_ERR-1:0] err_set,
    input logic [NUM_ERR-1:0] err_q,
    input logic               buf_q,
    input logic               buf_set,
    input logic               buf_irq_mask,
    input logic               tx_mode,
    input logic               last_char,
    input logic               mode_exit_clr,
    input logic               irq_n
);
    p_irq_on_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_q) |=> !irq_n);

    p_irq_on_buf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_q && !buf_irq_mask) |=> !irq_n);

    p_irq_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_q == '0) && !(buf_q && !buf_irq_mask)) |=> irq_n);

    p_last_char_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_q && tx_mode && last_char) |=> !buf_q);

    p_mode_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_exit_clr && !buf_set) |=> !buf_q);

    generate
        for (genvar i = 0; i < NUM_ERR; i++) begin : g_set
            p_set_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
                err_set[i] |=> err_q[i]);
        end
    endgenerate
endmodule

bind sc_irq_ctrl sc_irq_ctrl_chk #(.NUM_ERR(NUM_ERR)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .err_set       (err_set),
    .err_q         (err_q),
    .buf_q         (buf_q),
    .buf_set       (buf_set),
    .buf_irq_mask  (buf_irq_mask),
    .tx_mode       (tx_mode),
    .last_char     (last_char),
    .mode_exit_clr (mode_exit_clr),
    .irq_n         (irq_n)
);

// File: tb/sc_irq_ctrl_tb.sv
// Directed bench for sc_irq_ctrl: one task per scenario, each checking its own results.
module sc_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] err_set = '0;
    logic       buf_set = 1'b0;
    logic       last_char = 1'b0;
    logic       tx_mode = 1'b0;
    logic       fifo_full = 1'b0;
    logic       buf_irq_mask = 1'b0;
    logic       stat_rd_n = 1'b1;
    logic       tx_wr = 1'b0;
    logic       rx_rd = 1'b0;
    logic [6:0] stat_rdata;
    logic       irq_n;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sc_irq_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .err_set      (err_set),
        .buf_set      (buf_set),
        .last_char    (last_char),
        .tx_mode      (tx_mode),
        .fifo_full    (fifo_full),
        .buf_irq_mask (buf_irq_mask),
        .stat_rd_n    (stat_rd_n),
        .tx_wr        (tx_wr),
        .rx_rd        (rx_rd),
        .stat_rdata   (stat_rdata),
        .irq_n        (irq_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive stat_rd_n low long enough to snapshot, return data; leaves stat_rd_n high at a negedge.
    task automatic stat_read(output logic [6:0] snap);
        @(negedge clk) stat_rd_n = 1'b0;
        repeat (4) @(negedge clk);
        snap = stat_rdata;
        stat_rd_n = 1'b1;
    endtask

    task automatic pulse_err(input logic [5:0] bits);
        @(negedge clk) err_set = bits;
        @(negedge clk) err_set = '0;
    endtask

    task automatic pulse_buf();
        @(negedge clk) buf_set = 1'b1;
        @(negedge clk) buf_set = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 irq_n after reset", irq_n, 1);
        chk("R10 snapshot after reset", stat_rdata, 0);
    endtask

    task automatic t_read_clear_timing();
        logic [6:0] s;
        pulse_err(6'b000100);
        @(negedge clk);
        chk("R1 irq_n low on parity flag", irq_n, 0);
        stat_read(s);
        chk("R2 snapshot holds parity bit 2", s, 7'h04);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R11 irq_n still low on clear edge", irq_n, 0);
        @(negedge clk);
        chk("R3 irq_n high one edge after clear", irq_n, 1);
        wait_cyc(4);
        stat_read(s);
        chk("R3 snapshot empty after clear", s, 7'h00);
        wait_cyc(8);
    endtask

    task automatic t_late_flag_kept();
        logic [6:0] s;
        pulse_err(6'b110001);
        @(negedge clk) stat_rd_n = 1'b0;
        repeat (4) @(negedge clk);
        s = stat_rdata;
        chk("R2 snapshot framing+timeouts", s, 7'h31);
        err_set = 6'b000010;
        @(negedge clk) err_set = '0;
        stat_rd_n = 1'b1;
        wait_cyc(8);
        chk("R3 flag raised after snapshot keeps irq low", irq_n, 0);
        stat_read(s);
        chk("R3 only overrun remains", s, 7'h02);
        wait_cyc(8);
        chk("R11 irq_n released after overrun read", irq_n, 1);
    endtask

    task automatic t_set_wins();
        logic [6:0] s;
        pulse_err(6'b001000);
        stat_read(s);
        chk("R2 snapshot early answer", s, 7'h08);
        repeat (4) @(posedge clk);
        @(negedge clk) err_set = 6'b001000;
        @(negedge clk) err_set = '0;
        wait_cyc(3);
        chk("R4 irq low after set on clear edge", irq_n, 0);
        stat_read(s);
        chk("R4 early answer survives clear", s, 7'h08);
        wait_cyc(8);
        chk("R4 cleared by second read", irq_n, 1);
    endtask

    task automatic t_mask_and_rx();
        logic [6:0] s;
        buf_irq_mask = 1'b1;
        pulse_buf();
        wait_cyc(2);
        chk("R5 masked buffer flag leaves irq high", irq_n, 1);
        stat_read(s);
        chk("R5 masked flag visible in bit 6", s, 7'h40);
        wait_cyc(8);
        @(negedge clk) buf_irq_mask = 1'b0;
        wait_cyc(2);
        chk("R5 unmasked buffer flag pulls irq low", irq_n, 0);
        @(negedge clk) rx_rd = 1'b1;
        @(negedge clk) rx_rd = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R7 irq still low on rx clear edge", irq_n, 0);
        @(negedge clk);
        chk("R7 irq high after rx clear", irq_n, 1);
    endtask

    task automatic t_tx_wr();
        pulse_buf();
        wait_cyc(1);
        chk("R5 buffer flag raises irq", irq_n, 0);
        @(negedge clk) tx_wr = 1'b1;
        @(negedge clk) tx_wr = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R6 irq still low on tx clear edge", irq_n, 0);
        @(negedge clk);
        chk("R6 irq high after tx clear", irq_n, 1);
    endtask

    task automatic t_mode_switch();
        @(negedge clk) begin fifo_full = 1'b0; tx_mode = 1'b1; end
        wait_cyc(2);
        pulse_buf();
        wait_cyc(2);
        chk("R8 flag set in tx mode", irq_n, 0);
        @(negedge clk) tx_mode = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R8 exit clears flag when FIFO was not full", irq_n, 1);
        @(negedge clk) begin fifo_full = 1'b1; tx_mode = 1'b1; end
        wait_cyc(2);
        @(negedge clk) fifo_full = 1'b0;
        pulse_buf();
        wait_cyc(2);
        @(negedge clk) tx_mode = 1'b0;
        wait_cyc(3);
        chk("R8 exit keeps flag when FIFO was full", irq_n, 0);
        @(negedge clk) rx_rd = 1'b1;
        @(negedge clk) rx_rd = 1'b0;
        wait_cyc(4);
        chk("R7 rx read clears kept flag", irq_n, 1);
    endtask

    task automatic t_last_char();
        logic [6:0] s;
        @(negedge clk) begin tx_mode = 1'b1; last_char = 1'b1; end
        wait_cyc(2);
        pulse_buf();
        wait_cyc(3);
        chk("R9 last character leaves irq high", irq_n, 1);
        stat_read(s);
        chk("R9 buffer bit not set", s, 7'h00);
        wait_cyc(8);
        @(negedge clk) last_char = 1'b0;
        pulse_buf();
        wait_cyc(2);
        chk("R9 ordinary character still sets flag", irq_n, 0);
        @(negedge clk) tx_mode = 1'b0;
        wait_cyc(3);
        chk("R8 leaving tx clears flag", irq_n, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_clear_timing();
        t_late_flag_kept();
        t_set_wins();
        t_mask_and_rx();
        t_tx_wr();
        t_mode_switch();
        t_last_char();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule